// File: doc/BRIEF.md
# Stream Frame Length Fitter

This block sits in a byte-wide valid/ready stream and forces every frame into a length window whose lower and upper bounds are supplied at run time. A frame that is too long is cut at the upper bound, and the end-of-frame marker moves onto the last byte kept. The rest of that input frame is consumed and discarded. A frame that is too short is extended with zero bytes until it reaches the lower bound. Frames already inside the window pass through unchanged.

For every frame the block also produces one status record on a separate valid/ready port. The record holds the number of bytes that arrived, the number of bytes sent, and one flag each for truncation and padding. The record appears after the frame's final output byte has been taken. No new frame is accepted until the record has been consumed, so the record and the frame always belong together without any queue.

The data path is combinational while a frame is passing through: a byte moves from input to output in the same cycle. The bounds are read when the first byte of a frame is presented and are then held until the frame ends.

Top module: `frame_len_fit`

## Requirements
- R1: A frame whose length L satisfies min <= L <= max leaves with the same bytes in the same order and its end marker on byte L.
- R2: A frame longer than max leaves as exactly its first max bytes, with the end marker on byte max.
- R3: After a cut, the remaining input bytes of that frame are accepted and discarded up to and including the input end marker. out_valid stays low during that time.
- R4: A frame shorter than min is followed by zero-valued bytes until min bytes have left, with the end marker on byte min. in_ready is low while padding bytes are offered.
- R5: Each status record carries the count of accepted input bytes, the count of sent output bytes, st_trunc (1 when bytes were cut) and st_pad (1 when zero bytes were added).
- R6: st_valid rises in the cycle after the last output handshake of a frame, or after the input end-marker handshake when the frame was cut. The record then holds stable until taken, and in_ready is low while it waits.
- R7: The bounds are sampled when a frame's first byte is presented. Changing lim_min or lim_max later in the frame has no effect on that frame.
- R8: When lim_max is below lim_min, lim_max is used for both bounds, so every frame leaves with exactly lim_max bytes.
- R9: The counters restart for every frame, so consecutive single-byte frames each report an input length of 1.
- R10: After reset, out_valid and st_valid are low and the first frame is counted from zero.
- R11: Holding out_ready low at arbitrary cycles stalls the frame without losing or repeating any byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lim_min | input | LEN_W | Lower length bound in bytes |
| lim_max | input | LEN_W | Upper length bound in bytes, must be at least 1 |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_last | input | 1 | Input byte ends its frame |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_last | output | 1 | Output byte ends its frame |
| st_valid | output | 1 | Status record valid |
| st_ready | input | 1 | Sink accepts the status record |
| st_orig_len | output | LEN_W | Input byte count of the frame, saturating |
| st_out_len | output | LEN_W | Output byte count of the frame |
| st_trunc | output | 1 | Frame was cut at the upper bound |
| st_pad | output | 1 | Frame was extended with zero bytes |

## Verification
The assertions rely on three conditions: lim_max is never zero, no frame is longer than the counters can hold, and the source follows the handshake rules, so in_valid is not withdrawn while in_ready is low. The bench keeps every upper bound between 1 and 40 and every frame under 64 bytes. It changes inputs only on the falling edge and holds each input byte until its handshake is seen. Bound changes in the middle of a frame happen only after the first byte has been accepted, which is where the sampling rule applies.

// File: rtl/flf_pkg.sv
// Shared types for the frame length fitter.
// Assumes nothing beyond being compiled before the modules that import it.
package flf_pkg;

    // Phase of the frame currently being handled.
    typedef enum logic [1:0] {
        PH_PASS = 2'd0,   // forwarding input bytes
        PH_DROP = 2'd1,   // discarding bytes beyond the upper bound
        PH_FILL = 2'd2,   // emitting zero bytes up to the lower bound
        PH_REPT = 2'd3    // offering the status record
    } flf_phase_e;

endpackage

// File: rtl/flf_count.sv
// Saturating byte counter with synchronous clear.
// Assumes clr and inc never need to act in the same cycle; clr wins if they do.
module flf_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    // Count up by one per increment, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
        end else if (inc && value != TOP) begin
            value <= value + W'(1);
        end
    end
endmodule

// File: rtl/flf_limits.sv
// Resolves and holds the length window for one frame.
// While at_start is high the live bounds pass straight through (after the
// max-over-min rule) and are captured; otherwise the captured pair is used.
// Assumes at_start is high exactly while no byte of the current frame has moved.
module flf_limits #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         at_start,
    input  logic [W-1:0] live_min,
    input  logic [W-1:0] live_max,
    output logic [W-1:0] eff_min,
    output logic [W-1:0] eff_max
);
    logic [W-1:0] res_min;
    logic [W-1:0] held_min;
    logic [W-1:0] held_max;

    // Upper bound wins when the bounds are crossed.
    always_comb res_min = (live_max < live_min) ? live_max : live_min;

    // Choose live or held bounds.
    always_comb begin
        eff_min = at_start ? res_min  : held_min;
        eff_max = at_start ? live_max : held_max;
    end

    // Capture the bounds while the frame has not started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_min <= '0;
            held_max <= '1;
        end else if (at_start) begin
            held_min <= res_min;
            held_max <= live_max;
        end
    end

    a_r8_window_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        eff_min <= eff_max);

    a_r7_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_start && !$past(at_start)) |-> ($stable(eff_min) && $stable(eff_max)));
endmodule

// File: rtl/flf_ctrl.sv
// Frame phase controller and byte path of the length fitter.
// Forwards bytes combinationally, cuts at eff_max, pads to eff_min with zeros,
// then offers one status record built from the two counters.
// Assumes eff_max >= 1 and eff_min <= eff_max.
module flf_ctrl
    import flf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] eff_min,
    input  logic [W-1:0] eff_max,
    input  logic [W-1:0] icnt,
    input  logic [W-1:0] ocnt,
    output logic         at_start,
    output logic         icnt_inc,
    output logic         ocnt_inc,
    output logic         cnt_clr,
    input  logic [7:0]   in_data,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         in_last,
    output logic [7:0]   out_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic         out_last,
    output logic         st_valid,
    input  logic         st_ready,
    output logic         st_trunc,
    output logic         st_pad
);
    flf_phase_e phase_q, phase_d;
    logic       trunc_q, pad_q;
    logic       set_trunc, set_pad;
    logic [W-1:0] onext;
    logic       hit_max, reach_min;

    // Compare the next output count against the window.
    always_comb begin
        onext     = ocnt + W'(1);
        hit_max   = (onext == eff_max);
        reach_min = (onext >= eff_min);
        at_start  = (phase_q == PH_PASS) && (icnt == '0) && (ocnt == '0);
    end

    // Drive the handshakes and choose the next phase.
    always_comb begin
        phase_d   = phase_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_last  = 1'b0;
        st_valid  = 1'b0;
        icnt_inc  = 1'b0;
        ocnt_inc  = 1'b0;
        cnt_clr   = 1'b0;
        set_trunc = 1'b0;
        set_pad   = 1'b0;
        unique case (phase_q)
            PH_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_last  = hit_max || (in_last && reach_min);
                if (in_valid && out_ready) begin
                    icnt_inc = 1'b1;
                    ocnt_inc = 1'b1;
                    if (hit_max && !in_last) begin
                        phase_d   = PH_DROP;
                        set_trunc = 1'b1;
                    end else if (in_last && !reach_min) begin
                        phase_d = PH_FILL;
                        set_pad = 1'b1;
                    end else if (out_last) begin
                        phase_d = PH_REPT;
                    end
                end
            end
            PH_DROP: begin
                in_ready = 1'b1;
                icnt_inc = in_valid;
                if (in_valid && in_last) phase_d = PH_REPT;
            end
            PH_FILL: begin
                out_valid = 1'b1;
                out_data  = 8'h00;
                out_last  = reach_min;
                ocnt_inc  = out_ready;
                if (out_ready && reach_min) phase_d = PH_REPT;
            end
            PH_REPT: begin
                st_valid = 1'b1;
                if (st_ready) begin
                    phase_d = PH_PASS;
                    cnt_clr = 1'b1;
                end
            end
            default: phase_d = PH_PASS;
        endcase
    end

    // Phase register and per-frame flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PASS;
            trunc_q <= 1'b0;
            pad_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (cnt_clr) begin
                trunc_q <= 1'b0;
                pad_q   <= 1'b0;
            end else begin
                trunc_q <= trunc_q | set_trunc;
                pad_q   <= pad_q | set_pad;
            end
        end
    end

    always_comb begin
        st_trunc = trunc_q;
        st_pad   = pad_q;
    end

    a_r2_below_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ocnt < eff_max));

    a_r3_drop_only_after_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !out_valid) |-> trunc_q);

    a_r4_fill_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_ready) |-> (out_data == 8'h00));

    a_r6_input_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> !in_ready);

    a_r6_record_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(icnt) && $stable(ocnt)
                                     && $stable(st_trunc) && $stable(st_pad)));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> !(st_trunc && st_pad));

    a_r5_pad_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_pad) |-> (icnt < ocnt));

    a_r9_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (icnt != '0));
endmodule

// File: rtl/frame_len_fit.sv
// Top of the frame length fitter: byte stream in, length-fitted stream out,
// one status record per frame. Assumes lim_max >= 1 and a source that holds
// in_valid until accepted.
module frame_len_fit #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] lim_min,
    input  logic [LEN_W-1:0] lim_max,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_last,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last,
    output logic             st_valid,
    input  logic             st_ready,
    output logic [LEN_W-1:0] st_orig_len,
    output logic [LEN_W-1:0] st_out_len,
    output logic             st_trunc,
    output logic             st_pad
);
    logic [LEN_W-1:0] eff_min, eff_max, icnt, ocnt;
    logic at_start, icnt_inc, ocnt_inc, cnt_clr;

    flf_limits #(.W(LEN_W)) u_limits (
        .clk(clk), .rst_n(rst_n), .at_start(at_start),
        .live_min(lim_min), .live_max(lim_max),
        .eff_min(eff_min), .eff_max(eff_max)
    );

    flf_count #(.W(LEN_W)) u_in_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(icnt_inc), .value(icnt)
    );

    flf_count #(.W(LEN_W)) u_out_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(ocnt_inc), .value(ocnt)
    );

    flf_ctrl #(.W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .eff_min(eff_min), .eff_max(eff_max), .icnt(icnt), .ocnt(ocnt),
        .at_start(at_start), .icnt_inc(icnt_inc), .ocnt_inc(ocnt_inc), .cnt_clr(cnt_clr),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .st_valid(st_valid), .st_ready(st_ready), .st_trunc(st_trunc), .st_pad(st_pad)
    );

    // Status lengths come straight from the frozen counters.
    always_comb begin
        st_orig_len = icnt;
        st_out_len  = ocnt;
    end

    a_r10_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!st_valid && st_orig_len == '0 && st_out_len == '0));
endmodule

// File: tb/tb_frame_len_fit.sv
module tb_frame_len_fit;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] lim_min = '0, lim_max = 16'd8;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0, st_ready = 1'b0;
    logic          in_ready, out_valid, out_last, st_valid, st_trunc, st_pad;
    logic [7:0]    out_data;
    logic [LW-1:0] st_orig_len, st_out_len;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    frame_len_fit #(.LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .lim_min(lim_min), .lim_max(lim_max),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .st_valid(st_valid), .st_ready(st_ready), .st_orig_len(st_orig_len),
        .st_out_len(st_out_len), .st_trunc(st_trunc), .st_pad(st_pad)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 7 + 3) & 255);
    endfunction

    // One frame through the block; results compared with a model of the window rules.
    task automatic run_frame(input string tag, input int len, input int mn, input int mx,
                             input int seed, input bit stall, input bit change_mid);
        logic [7:0] got_b[64];
        int got = 0, bad_bytes = 0, pad_busy = 0, drop_out = 0, wait_st = 0;
        int emin, elen, k = 0;
        bit etr, epd, done = 0;
        logic [LW-1:0] r_orig, r_out;
        logic r_tr, r_pd;
        emin = (mx < mn) ? mx : mn;
        etr  = (len > mx);
        epd  = (len < emin);
        elen = etr ? mx : (epd ? emin : len);
        @(negedge clk);
        lim_min = LW'(mn);
        lim_max = LW'(mx);
        fork
            begin
                for (int i = 0; i < len; i++) begin
                    if (i != 0) @(negedge clk);
                    if (change_mid && i == 1) begin
                        lim_min = 16'd2;
                        lim_max = 16'd3;
                    end
                    in_valid = 1'b1;
                    in_data  = pat(seed, i);
                    in_last  = (i == len - 1);
                    #1;
                    while (!in_ready) begin @(negedge clk); #1; end
                end
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            begin
                #0;
                while (!done) begin
                    out_ready = stall ? ((k % 3) != 2) : 1'b1;
                    k++;
                    #1;
                    if (out_valid && out_ready) begin
                        if (got < 64) got_b[got] = out_data;
                        if (got >= len && in_ready) pad_busy++;
                        got++;
                        if (out_last) done = 1;
                    end
                    if (!done) @(negedge clk);
                end
                @(negedge clk);
                out_ready = 1'b0;
                st_ready  = 1'b1;
                #1;
                while (!st_valid && wait_st < 200) begin
                    if (out_valid) drop_out++;
                    wait_st++;
                    @(negedge clk);
                    #1;
                end
                r_orig = st_orig_len; r_out = st_out_len; r_tr = st_trunc; r_pd = st_pad;
                @(negedge clk);
                st_ready = 1'b0;
            end
        join
        check(tag, "output length", got, elen);
        for (int i = 0; i < elen && i < got && i < 64; i++)
            if (got_b[i] !== ((i < len) ? pat(seed, i) : 8'h00)) bad_bytes++;
        check(tag, "mismatching bytes", bad_bytes, 0);
        check("R5", "status orig length", int'(r_orig), len);
        check("R5", "status out length", int'(r_out), elen);
        check("R5", "status trunc flag", int'(r_tr), int'(etr));
        check("R5", "status pad flag", int'(r_pd), int'(epd));
        if (!etr) check("R6", "cycles from last handshake to status", wait_st, 0);
        if (etr)  check("R3", "output beats while discarding", drop_out, 0);
        if (epd)  check("R4", "in_ready high during padding", pad_busy, 0);
        if (change_mid) begin
            lim_min = LW'(mn);
            lim_max = LW'(mx);
        end
    endtask

    // Status record withheld: input must stay blocked and record must hold.
    task automatic status_blocks_input();
        int leaks = 0, drops = 0;
        @(negedge clk);
        lim_min = 16'd1; lim_max = 16'd8; out_ready = 1'b1; st_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (i != 0) @(negedge clk);
            in_valid = 1'b1; in_data = pat(5, i); in_last = (i == 2);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_data = 8'h5A; in_last = 1'b1;
        for (int c = 0; c < 4; c++) begin
            #1;
            if (in_ready) leaks++;
            if (!st_valid || st_orig_len != 16'd3) drops++;
            @(negedge clk);
        end
        check("R6", "in_ready while record pending", leaks, 0);
        check("R6", "record lost while pending", drops, 0);
        in_valid = 1'b0; in_last = 1'b0; st_ready = 1'b1;
        @(negedge clk);
        st_ready = 1'b0;
        #1;
        check("R6", "st_valid after record taken", int'(st_valid), 0);
        check("R6", "in_ready after record taken", int'(in_ready), 1);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", "out_valid after reset", int'(out_valid), 0);
        check("R10", "st_valid after reset", int'(st_valid), 0);
        run_frame("R10", 4, 1, 8, 1, 1'b0, 1'b0);
        run_frame("R1", 6, 2, 10, 2, 1'b0, 1'b0);
        run_frame("R1", 10, 10, 10, 3, 1'b0, 1'b0);
        run_frame("R2", 20, 1, 7, 4, 1'b0, 1'b0);
        run_frame("R2", 9, 1, 8, 5, 1'b0, 1'b0);
        run_frame("R4", 3, 12, 20, 6, 1'b0, 1'b0);
        run_frame("R4", 1, 2, 4, 7, 1'b0, 1'b0);
        run_frame("R11", 15, 4, 40, 8, 1'b1, 1'b0);
        run_frame("R11", 2, 9, 40, 9, 1'b1, 1'b0);
        run_frame("R11", 30, 1, 12, 10, 1'b1, 1'b0);
        run_frame("R7", 10, 4, 20, 11, 1'b0, 1'b1);
        run_frame("R8", 3, 9, 5, 12, 1'b0, 1'b0);
        run_frame("R8", 12, 9, 5, 13, 1'b0, 1'b0);
        for (int f = 0; f < 5; f++) run_frame("R9", 1, 1, 8, 20 + f, 1'b0, 1'b0);
        status_blocks_input();
        run_frame("R9", 1, 0, 8, 30, 1'b0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule